// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block moves one byte at a time over a single bidirectional data pin while it emits its own shift clock. A byte write while the port is idle starts a transmission. The byte goes out least significant bit first, one bit per bit slot, with the pin driven. If no write is pending, the receive enable is high and the receive-done flag is clear, the port starts a reception instead. It releases the pin and captures eight bits on the rising edges of the shift clock, also least significant bit first. At the end, the captured byte is presented on `rx_byte`.

Each bit slot lasts `CYC` cycles of `clk` (default 12). The shift clock is high when the port is idle. Within a slot it goes low for a short window and rises `HOLD` cycles (default 2) before the slot ends. Outgoing data changes only at slot boundaries, so each bit is set up `CYC-HOLD` cycles before the rising edge and held `HOLD` cycles after it. A completion flag for each direction is set when the eighth bit slot ends. It stays set until a one-cycle clear pulse removes it.

Top module: `sync_shift_port`

## Requirements
- R1: A `wr_stb` pulse sampled while idle starts a transmission of `wr_data`. Bit k (k = 0..7, bit 0 first) is driven on `sd_o` during bit slot k, and `sd_oe` is high for all 96 cycles of the transfer.
- R2: The first bit slot begins on the clock edge that accepts the start. During a transfer `sclk` is low in slot cycles 5..9 and high in cycles 0..4, 10 and 11, giving a 12-cycle period. `sclk` stays high while idle.
- R3: `sd_o` changes only at slot boundaries. It is therefore stable for the 10 cycles before each `sclk` rising edge and for the 2 cycles after it.
- R4: When `rx_en` is high, `rx_done` is low and no write is sampled while idle, a reception runs. `sd_oe` is low throughout it. `sd_i` is sampled only on the clock edge where `sclk` rises, bit 0 first. The byte appears on `rx_byte` when the reception ends.
- R5: `tx_done` (or `rx_done` for a reception) goes high exactly 96 cycles after the start edge, on the edge that ends the eighth slot.
- R6: A completion flag stays set until its clear input is sampled high. A clear that lands on the same edge as a new completion leaves the flag set.
- R7: A `wr_stb` sampled during a transmission or a reception is ignored. The transfer in progress is unchanged and no transmission follows it.
- R8: No reception starts while `rx_done` is set, even with `rx_en` high. `sclk` stays high and `rx_byte` keeps its value.
- R9: When a write and the receive condition are sampled on the same idle edge, the transmission wins and no reception runs.
- R10: After reset, `sclk` is high, `sd_oe` is low, both flags are low and `rx_byte` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Byte write strobe, one cycle |
| wr_data | input | W | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| tx_done_clr | input | 1 | Clears the transmit-done flag |
| rx_done_clr | input | 1 | Clears the receive-done flag |
| sd_i | input | 1 | Data pin input value |
| rx_byte | output | W | Last received byte |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| sclk | output | 1 | Shift clock |
| sd_o | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |

## Verification
Two pairs of events can land on the same edge. The first pair is a flag clear and the completion of a new transfer. The bench lets `tx_done` stay set from a prior transmission and then asserts `tx_done_clr` so that the port samples it on the very edge that ends the next transmission. The flag must read high afterwards. The second pair is a write and a reception start on the same idle edge. The bench raises `wr_stb` and `rx_en` together and judges the result by `sd_oe` staying high, by the transmitted bit stream, and by `rx_done` remaining low.

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int W    = 8,
  parameter int CYC  = 12,
  parameter int HOLD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         rx_en,
  input  logic         tx_done_clr,
  input  logic         rx_done_clr,
  input  logic         sd_i,
  output logic [W-1:0] rx_byte,
  output logic         tx_done,
  output logic         rx_done,
  output logic         sclk,
  output logic         sd_o,
  output logic         sd_oe
);
  localparam int RISE = CYC - HOLD;
  localparam int FALL = RISE / 2;
  localparam int PW   = $clog2(CYC);
  localparam int BW   = $clog2(W);

  logic          busy, rxm;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [W-1:0]  sh;

  wire slot_end = busy && (ph == PW'(CYC - 1));
  wire last     = slot_end && (bitn == BW'(W - 1));
  wire smp      = busy && rxm && (ph == PW'(RISE - 1));

  assign sclk  = !(busy && (ph >= PW'(FALL)) && (ph < PW'(RISE)));
  assign sd_o  = sh[0];
  assign sd_oe = busy && !rxm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rxm     <= 1'b0;
      ph      <= '0;
      bitn    <= '0;
      sh      <= '0;
      rx_byte <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      tx_done <= (tx_done && !tx_done_clr) || (last && !rxm);
      rx_done <= (rx_done && !rx_done_clr) || (last && rxm);
      if (!busy) begin
        if (wr_stb) begin
          busy <= 1'b1;
          rxm  <= 1'b0;
          sh   <= wr_data;
          ph   <= '0;
          bitn <= '0;
        end else if (rx_en && !rx_done) begin
          busy <= 1'b1;
          rxm  <= 1'b1;
          ph   <= '0;
          bitn <= '0;
        end
      end else begin
        if (smp) sh <= {sd_i, sh[W-1:1]};
        if (slot_end) begin
          ph   <= '0;
          bitn <= bitn + BW'(1);
          if (!rxm) sh <= {1'b0, sh[W-1:1]};
          if (last) begin
            busy <= 1'b0;
            if (rxm) rx_byte <= sh;
          end
        end else begin
          ph <= ph + PW'(1);
        end
      end
    end
  end

  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> $stable(sd_o));
  a_r2_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |=> !sclk);
  a_r6_tx_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !tx_done_clr |=> tx_done);
  a_r6_rx_flag_keep: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_done_clr |=> rx_done);
  a_r5_tx_flag_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(busy) && !$past(rxm) && !busy);
  a_r4_rx_flag_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(busy) && $past(rxm) && !busy);
  a_r8_no_rx_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rx_done && !wr_stb |=> !busy);
  a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_stb && !last |=> busy && (rxm == $past(rxm)));
endmodule

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_stb = 1'b0, rx_en = 1'b0, tx_done_clr = 1'b0, rx_done_clr = 1'b0, sd_i = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rx_byte;
  logic       tx_done, rx_done, sclk, sd_o, sd_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_shift_port i_sync_shift_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .rx_en(rx_en),
    .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr), .sd_i(sd_i),
    .rx_byte(rx_byte), .tx_done(tx_done), .rx_done(rx_done),
    .sclk(sclk), .sd_o(sd_o), .sd_oe(sd_oe));

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_sclk(input int n);
    int ph = (n - 1) % 12;
    return !(n <= 96 && ph >= 5 && ph <= 9);
  endfunction

  task automatic xfer(input bit is_tx, input logic [7:0] d, input bit both,
                      input int poke_n, input bit clr_at_end, input bit flag_before);
    int bad_clk = 0, bad_dat = 0, bad_oe = 0, bad_flag = 0;
    @(negedge clk);
    if (is_tx) begin wr_stb = 1'b1; wr_data = d; end
    if (!is_tx || both) rx_en = 1'b1;
    for (int n = 1; n <= 97; n++) begin
      @(negedge clk);
      if (sclk !== exp_sclk(n)) bad_clk++;
      if (sd_oe !== (n <= 96 && is_tx)) bad_oe++;
      if (is_tx && n <= 96 && sd_o !== d[(n - 1) / 12]) bad_dat++;
      if ((is_tx ? tx_done : rx_done) !== ((n == 97) ? 1'b1 : flag_before)) bad_flag++;
      if (n == 1) begin wr_stb = 1'b0; if (both) rx_en = 1'b0; end
      if (n == poke_n) begin wr_stb = 1'b1; wr_data = ~d; end
      if (n == poke_n + 1) wr_stb = 1'b0;
      if (n / 12 < 8) sd_i = (n % 12 == 10) ? d[n / 12] : ~d[n / 12];
      if (clr_at_end && n == 96) begin
        if (is_tx) tx_done_clr = 1'b1; else rx_done_clr = 1'b1;
      end
      if (n == 97) begin tx_done_clr = 1'b0; rx_done_clr = 1'b0; end
    end
    chk("R2 shift clock shape", bad_clk == 0, bad_clk, 0);
    chk(is_tx ? "R1 pin driven" : "R4 pin released", bad_oe == 0, bad_oe, 0);
    chk(clr_at_end ? "R6 set beats clear" : "R5 flag timing", bad_flag == 0, bad_flag, 0);
    if (is_tx) chk("R1 R3 bit stream", bad_dat == 0, bad_dat, 0);
    else chk("R4 received byte", rx_byte === d, rx_byte, d);
  endtask

  task automatic idle_chk(input string req, input int cyc);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (sclk !== 1'b1 || sd_oe !== 1'b0) bad++;
    end
    chk(req, bad == 0, bad, 0);
  endtask

  task automatic clr_flags();
    @(negedge clk); rx_en = 1'b0; tx_done_clr = 1'b1; rx_done_clr = 1'b1;
    @(negedge clk); tx_done_clr = 1'b0; rx_done_clr = 1'b0;
    chk("R6 clear", tx_done === 1'b0 && rx_done === 1'b0, {tx_done, rx_done}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, keep;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset sclk", sclk === 1'b1, sclk, 1);
    chk("R10 reset oe", sd_oe === 1'b0, sd_oe, 0);
    chk("R10 reset flags", tx_done === 1'b0 && rx_done === 1'b0, {tx_done, rx_done}, 0);
    chk("R10 reset rx_byte", rx_byte === 8'h00, rx_byte, 0);

    xfer(1, 8'h00, 0, 0, 0, 0); clr_flags();
    xfer(1, 8'hFF, 0, 0, 0, 0); clr_flags();
    for (int i = 0; i < 5; i++) begin
      d = 8'($urandom);
      xfer(1, d, 0, 0, 0, 0); clr_flags();
    end
    xfer(0, 8'hA5, 0, 0, 0, 0); clr_flags();
    for (int i = 0; i < 5; i++) begin
      d = 8'($urandom);
      xfer(0, d, 0, 0, 0, 0); clr_flags();
    end

    d = 8'($urandom);
    xfer(1, d, 0, 40, 0, 0);
    idle_chk("R7 write during transmit ignored", 30);
    clr_flags();

    d = 8'h3C;
    xfer(0, d, 0, 30, 0, 0);
    chk("R7 no transmit after write during receive", tx_done === 1'b0, tx_done, 0);
    keep = rx_byte;
    idle_chk("R8 no reception while flag set", 40);
    chk("R8 rx_byte kept", rx_byte === keep, rx_byte, keep);
    chk("R8 flag kept", rx_done === 1'b1, rx_done, 1);
    clr_flags();

    xfer(1, 8'h96, 0, 0, 0, 0);
    xfer(1, 8'h69, 0, 0, 1, 1);
    clr_flags();

    d = 8'($urandom);
    xfer(1, d, 1, 0, 0, 0);
    chk("R9 transmit wins, no receive flag", rx_done === 1'b0, rx_done, 0);
    idle_chk("R9 no reception afterwards", 20);
    clr_flags();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule